// File: doc/BRIEF.md
# UV-Erasable Byte Store Model

This block is a clocked, synthesizable stand-in for a 2048-by-8 ultraviolet-erasable programmable memory. It decodes the operating mode from an active-low chip-enable/program pin, an active-low output enable and a digital flag that stands for the high programming voltage. A bit can only be driven from 1 to 0 by a timed program pulse, and it goes back to 1 only through a bulk erase. Output drive is signalled by a separate enable rather than a real three-state pin, and data out reads zero whenever that enable is low.

A write happens only when the program pin stays high for a number of clocks inside a window set by parameters. A pulse that is too short, too long or aborted leaves the array untouched and sets a sticky error flag. A bulk erase walks the array one address per clock, writing all ones. While it runs, a busy flag is raised and every other operation is ignored. The same sweep runs on its own after reset, so the block comes out of reset blank.

Top module: `uvb_store`

## Requirements
- R1: The array holds 2^AW bytes of DW bits (2048 by 8 by default). After reset, status bit 0 (busy) stays 1 for 2^AW clocks while the array is filled with all ones. After that, every byte reads 0xFF.
- R2: With chip enable low, output enable low and the voltage flag low (read), `drive_o` is 1 and `dout_o` shows the addressed byte one clock after the inputs are applied.
- R3: With the voltage flag high, chip enable low and output enable low (verify), `drive_o` is 1 and `dout_o` shows the stored byte.
- R4: With output enable high and the voltage flag low, `drive_o` is 0 and `dout_o` is 0, whatever chip enable and the address are.
- R5: With chip enable high and the block not in program mode (program mode means voltage flag high and output enable high), `standby_o` is 1 and `drive_o` is 0, whatever output enable is.
- R6: In program mode, suppose chip enable is high for N consecutive clocks and then low, with PULSE_MIN <= N <= PULSE_MAX. The byte at the address then becomes its old value ANDed with `din_i`, using the address and data present in the clock where the pin is first seen low.
- R7: Writes can only clear bits. Writing data over an already written byte leaves the AND of both. Repeating a pulse with the same data leaves the byte unchanged.
- R8: A pulse with N below PULSE_MIN or above PULSE_MAX leaves the array unchanged and sets status bit 1 (pulse error). A pulse aborted because the voltage flag or output enable changes while the pin is high does the same. The error bit stays set until reset.
- R9: With the voltage flag high, output enable high and chip enable held low (inhibit), nothing is written and `drive_o` is 0.
- R10: An erase request seen while idle raises busy on the next clock for exactly 2^AW clocks and leaves every byte at 0xFF. A further request while busy does not lengthen the sweep.
- R11: While busy, the block ignores program pulses and does not drive data out. Such pulses write nothing and set no error.
- R12: If an erase request arrives on the same clock as a committing program pulse, the erase wins: the byte ends at 0xFF and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the blanking sweep |
| addr_i | input | AW | Byte address |
| ce_pgm_n_i | input | 1 | Active-low chip enable; its high pulse is the program strobe |
| oe_n_i | input | 1 | Active-low output enable |
| hv_i | input | 1 | High programming voltage present |
| din_i | input | DW | Data to program |
| erase_req_i | input | 1 | Bulk erase request |
| dout_o | output | DW | Read data, zero when not driving |
| drive_o | output | 1 | Output drive enable |
| standby_o | output | 1 | Standby indicator |
| status_o | output | 2 | Bit 0 busy, bit 1 sticky pulse error |

## Verification
Two of this block's functions can fall in the same cycle: the commit at the falling edge of a program pulse and the acceptance of a bulk erase request. The bench raises the erase request in the very clock where the program pin returns low after a valid-length pulse.

The result is judged in three ways. The written byte must read back 0xFF. The error bit must stay clear. Busy must fall exactly 2^AW clocks after the request, even though a second request and a valid pulse are issued mid-sweep.

// File: rtl/uvb_pkg.sv
package uvb_pkg;
   typedef enum logic [2:0] {
      M_READ,
      M_VERIFY,
      M_DESEL,
      M_STBY,
      M_PROG,
      M_INHIBIT
   } mode_e;
endpackage

// File: rtl/uvb_mode_dec.sv
module uvb_mode_dec
   import uvb_pkg::*;
(
   input  logic  ce_n,
   input  logic  oe_n,
   input  logic  hv,
   output mode_e mode
);
   always_comb begin
      if (hv && oe_n)  mode = ce_n ? M_PROG : M_INHIBIT;
      else if (ce_n)   mode = M_STBY;
      else if (oe_n)   mode = M_DESEL;
      else             mode = hv ? M_VERIFY : M_READ;
   end
endmodule

// File: rtl/uvb_pulse_timer.sv
module uvb_pulse_timer #(
   parameter int PULSE_MIN = 4,
   parameter int PULSE_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic prog_pulse,
   input  logic prog_fam,
   output logic commit,
   output logic err
);
   localparam int CW = $clog2(PULSE_MAX + 2);
   localparam logic [CW-1:0] SAT  = CW'(PULSE_MAX + 1);
   localparam logic [CW-1:0] LO_C = CW'(PULSE_MIN);
   localparam logic [CW-1:0] HI_C = CW'(PULSE_MAX);

   logic [CW-1:0] cnt_q;
   logic          hi_q, err_q;
   logic          ends, ok;

   assign ends   = hi_q && !prog_pulse && !busy;
   assign ok     = prog_fam && (cnt_q >= LO_C) && (cnt_q <= HI_C);
   assign commit = ends && ok;
   assign err    = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
         err_q <= 1'b0;
      end else if (busy) begin
         cnt_q <= '0;
         hi_q  <= 1'b0;
      end else if (prog_pulse) begin
         hi_q <= 1'b1;
         if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      end else begin
         hi_q  <= 1'b0;
         cnt_q <= '0;
         if (hi_q && !ok) err_q <= 1'b1;
      end
   end

   // R8: once set, the pulse error stays set
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   // R6: a commit always closes a pulse that was seen in program mode
   a_r6_commit_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(prog_pulse));
endmodule

// File: rtl/uvb_array.sv
module uvb_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          erase_req,
   input  logic          commit,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] rd_q,
   output logic          busy
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] idx_q;
   logic          busy_q;

   assign busy = busy_q;

   always_ff @(posedge clk) begin
      rd_q <= mem[addr];
      if (busy_q)      mem[idx_q] <= '1;
      else if (commit) mem[addr]  <= mem[addr] & din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (busy_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST) busy_q <= 1'b0;
      end else if (erase_req) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end
   end

   // R10: an idle erase request starts the sweep on the next clock
   a_r10_erase_start: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && !busy_q) |=> busy_q);
   // R11: no program commit reaches the array during a sweep
   a_r11_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !commit);
endmodule

// File: rtl/uvb_store.sv
module uvb_store
   import uvb_pkg::*;
#(
   parameter int AW        = 11,
   parameter int DW        = 8,
   parameter int PULSE_MIN = 4,
   parameter int PULSE_MAX = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          ce_pgm_n_i,
   input  logic          oe_n_i,
   input  logic          hv_i,
   input  logic [DW-1:0] din_i,
   input  logic          erase_req_i,
   output logic [DW-1:0] dout_o,
   output logic          drive_o,
   output logic          standby_o,
   output logic [1:0]    status_o
);
   if (AW < 1 || DW < 1) begin : g_bad_geom
      $error("uvb_store: AW and DW must be at least 1");
   end
   if (PULSE_MIN < 1 || PULSE_MAX < PULSE_MIN) begin : g_bad_win
      $error("uvb_store: pulse window must satisfy 1 <= PULSE_MIN <= PULSE_MAX");
   end

   mode_e         mode;
   logic          busy, commit, err;
   logic [DW-1:0] rd_q;
   logic          drive_q, stby_q;

   uvb_mode_dec u_dec (
      .ce_n (ce_pgm_n_i),
      .oe_n (oe_n_i),
      .hv   (hv_i),
      .mode (mode)
   );

   uvb_pulse_timer #(.PULSE_MIN(PULSE_MIN), .PULSE_MAX(PULSE_MAX)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .prog_pulse (mode == M_PROG),
      .prog_fam   ((mode == M_PROG) || (mode == M_INHIBIT)),
      .commit     (commit),
      .err        (err)
   );

   uvb_array #(.AW(AW), .DW(DW)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_req (erase_req_i),
      .commit    (commit),
      .addr      (addr_i),
      .din       (din_i),
      .rd_q      (rd_q),
      .busy      (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         stby_q  <= 1'b0;
      end else begin
         drive_q <= ((mode == M_READ) || (mode == M_VERIFY)) && !busy;
         stby_q  <= (mode == M_STBY);
      end
   end

   assign drive_o   = drive_q;
   assign standby_o = stby_q;
   assign dout_o    = drive_q ? rd_q : '0;
   assign status_o  = {err, busy};

   // R4: output enable high outside programming leaves the bus undriven
   a_r4_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n_i && !hv_i) |=> !drive_o);
   // R5: chip enable high outside program mode means standby, no drive
   a_r5_standby: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_pgm_n_i && !(hv_i && oe_n_i)) |=> (standby_o && !drive_o));
endmodule

// File: tb/uvb_store_tb.sv
module uvb_store_tb_top;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int PMIN = 4;
   localparam int PMAX = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          ce_pgm_n_i = 1'b1;
   logic          oe_n_i = 1'b1;
   logic          hv_i = 1'b0;
   logic [DW-1:0] din_i = '0;
   logic          erase_req_i = 1'b0;
   logic [DW-1:0] dout_o;
   logic          drive_o, standby_o;
   logic [1:0]    status_o;

   always #2.5 clk = ~clk;

   uvb_store #(.AW(AW), .DW(DW), .PULSE_MIN(PMIN), .PULSE_MAX(PMAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_pgm_n_i(ce_pgm_n_i),
      .oe_n_i(oe_n_i), .hv_i(hv_i), .din_i(din_i), .erase_req_i(erase_req_i),
      .dout_o(dout_o), .drive_o(drive_o), .standby_o(standby_o), .status_o(status_o)
   );

   typedef struct {
      int         due;
      bit         is_st;
      logic       drv;
      logic [7:0] dat;
      logic       stby;
      logic [1:0] st;
      string      req;
   } item_t;

   item_t      sb[$];
   int         cyc = 0;
   int         runs = 0;
   int         fails = 0;
   bit         done = 1'b0;
   logic [7:0] ref_mem [DEPTH];
   logic       ref_err = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items when their sampling point is reached
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         runs++;
         if (it.is_st) begin
            if (status_o !== it.st) begin
               fails++;
               $display("FAIL %s: status actual=%b expected=%b", it.req, status_o, it.st);
            end
         end else if ({drive_o, dout_o, standby_o} !== {it.drv, it.dat, it.stby}) begin
            fails++;
            $display("FAIL %s: drv/dout/stby actual=%b/%h/%b expected=%b/%h/%b",
                     it.req, drive_o, dout_o, standby_o, it.drv, it.dat, it.stby);
         end
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
   end

   task automatic exp_out(logic drv, logic [7:0] dat, logic stby, string req);
      item_t it;
      it.due = cyc + 1; it.is_st = 1'b0; it.drv = drv; it.dat = dat;
      it.stby = stby; it.st = '0; it.req = req;
      sb.push_back(it);
   endtask

   task automatic exp_st(logic [1:0] st, string req);
      item_t it;
      it.due = cyc + 1; it.is_st = 1'b1; it.drv = 1'b0; it.dat = '0;
      it.stby = 1'b0; it.st = st; it.req = req;
      sb.push_back(it);
   endtask

   task automatic pins(logic [AW-1:0] a, logic ce, logic oe, logic hv, logic [7:0] d);
      addr_i = a; ce_pgm_n_i = ce; oe_n_i = oe; hv_i = hv; din_i = d;
   endtask

   task automatic rd(logic [AW-1:0] a, logic hv, string req);
      pins(a, 1'b0, 1'b0, hv, 8'h00);
      exp_out(1'b1, ref_mem[a], 1'b0, req);
      @(negedge clk);
   endtask

   task automatic fill_ref();
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
   endtask

   // program pulse of n clocks; erase raises the request on the falling clock
   task automatic prog(logic [AW-1:0] a, logic [7:0] d, int n, bit erase, bit ignored);
      pins(a, 1'b0, 1'b1, 1'b1, d);
      @(negedge clk);
      ce_pgm_n_i = 1'b1;
      repeat (n) @(negedge clk);
      ce_pgm_n_i = 1'b0;
      erase_req_i = erase;
      @(negedge clk);
      erase_req_i = 1'b0;
      if (erase) fill_ref();
      else if (!ignored) begin
         if (n >= PMIN && n <= PMAX) ref_mem[a] = ref_mem[a] & d;
         else ref_err = 1'b1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      pins('0, 1'b1, 1'b1, 1'b0, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fill_ref();
      ref_err = 1'b0;
   endtask

   initial begin
      int c0;
      do_reset();
      exp_st(2'b01, "R1 busy after reset");
      exp_out(1'b0, 8'h00, 1'b1, "R1 reset outputs");
      repeat (DEPTH + 2) @(negedge clk);
      exp_st(2'b00, "R1 sweep done");
      @(negedge clk);
      rd(0, 1'b0, "R1 blank low");
      rd(11'd2047, 1'b0, "R1 blank high");
      rd(11'd1000, 1'b0, "R2 blank read");

      prog(11'd5, 8'hA5, 6, 1'b0, 1'b0);
      rd(11'd5, 1'b0, "R6 write in window");
      rd(11'd5, 1'b1, "R3 verify");
      prog(11'd5, 8'h0F, 6, 1'b0, 1'b0);
      rd(11'd5, 1'b1, "R7 AND over old byte");
      prog(11'd5, 8'h0F, 6, 1'b0, 1'b0);
      rd(11'd5, 1'b0, "R7 repeat harmless");
      prog(11'd0, 8'h12, PMIN, 1'b0, 1'b0);
      rd(11'd0, 1'b0, "R6 minimum width");
      prog(11'd2047, 8'h80, PMAX, 1'b0, 1'b0);
      rd(11'd2047, 1'b0, "R6 maximum width");
      exp_st(2'b00, "R6 no error");
      @(negedge clk);

      // inhibit: held low with new data must not write
      pins(11'd0, 1'b0, 1'b1, 1'b1, 8'h00);
      repeat (5) @(negedge clk);
      exp_out(1'b0, 8'h00, 1'b0, "R9 inhibit no drive");
      @(negedge clk);
      rd(11'd0, 1'b0, "R9 inhibit no write");

      pins(11'd5, 1'b0, 1'b1, 1'b0, 8'h00);
      exp_out(1'b0, 8'h00, 1'b0, "R4 deselect");
      @(negedge clk);
      pins(11'd7, 1'b1, 1'b1, 1'b0, 8'h00);
      exp_out(1'b0, 8'h00, 1'b1, "R4 deselect with ce high");
      @(negedge clk);
      pins(11'd5, 1'b1, 1'b0, 1'b0, 8'h00);
      exp_out(1'b0, 8'h00, 1'b1, "R5 standby with oe low");
      @(negedge clk);

      // R12: erase request on the committing clock
      prog(11'd7, 8'h00, 5, 1'b1, 1'b0);
      c0 = cyc;
      exp_st(2'b01, "R10 busy after request");
      @(negedge clk);
      @(negedge clk);
      rd(11'd5, 1'b0, "R11 no drive while busy");
      sb[sb.size()-1].drv = 1'b0;
      sb[sb.size()-1].dat = 8'h00;
      prog(11'd9, 8'h00, 5, 1'b0, 1'b1);
      erase_req_i = 1'b1;
      @(negedge clk);
      erase_req_i = 1'b0;
      pins('0, 1'b1, 1'b1, 1'b0, 8'h00);
      while (cyc < c0 + DEPTH - 2) @(negedge clk);
      exp_st(2'b01, "R10 busy last clock");
      @(negedge clk);
      exp_st(2'b00, "R12 sweep length and no error");
      @(negedge clk);
      rd(11'd7, 1'b0, "R12 erase wins");
      rd(11'd9, 1'b0, "R11 pulse ignored");
      rd(11'd5, 1'b0, "R10 byte erased");

      prog(11'd10, 8'h00, PMIN - 1, 1'b0, 1'b0);
      exp_st(2'b10, "R8 short pulse error");
      @(negedge clk);
      rd(11'd10, 1'b0, "R8 short pulse no write");
      prog(11'd11, 8'h00, PMAX + 1, 1'b0, 1'b0);
      rd(11'd11, 1'b0, "R8 long pulse no write");

      do_reset();
      repeat (DEPTH + 2) @(negedge clk);
      pins(11'd12, 1'b0, 1'b1, 1'b1, 8'h00);
      @(negedge clk);
      ce_pgm_n_i = 1'b1;
      repeat (5) @(negedge clk);
      oe_n_i = 1'b0;
      @(negedge clk);
      ce_pgm_n_i = 1'b0;
      @(negedge clk);
      exp_st(2'b10, "R8 abort error");
      @(negedge clk);
      rd(11'd12, 1'b0, "R8 abort no write");
      prog(11'd13, 8'hF0, 5, 1'b0, 1'b0);
      exp_st(2'b10, "R8 error sticky");
      @(negedge clk);
      rd(11'd13, 1'b0, "R6 write after error");

      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule